// File: doc/BRIEF.md
# Scatter-Gather Byte Stream Sequencer

This block sits in front of a message digest core and supplies its input bytes. It is launched by a one-cycle start pulse that carries a base address, a mode selection and, for a single-buffer job, a byte count. In gather mode the base address points at a chain of descriptors. Each descriptor sits in eight bytes of memory and holds two little-endian 32-bit words. The count word comes first, and its top bit marks the final descriptor. The buffer address word follows it. The sequencer reads each descriptor, fetches the bytes of the buffer it names and presents them one at a time on a valid/ready byte output. The segments join into one message whatever their sizes. In direct mode the base address is the data itself and the count input gives the message length.

Memory is read through a simple request/response port that fetches one aligned 32-bit word at a time. A buffer may start at any byte address. After the message ends, a one-cycle done pulse is issued. For a job started in accumulate mode the data already carries its own padding and length field, so the done pulse comes with a flag that tells the digest core to skip its own padding.

Top module: `sg_gather_seq`

## Requirements
- R1: After reset the block is idle: no output byte is valid, no memory request is raised and done is low.
- R2: In direct mode (sg_en_i low at start) the output carries byte_cnt_i bytes read from src_addr_i upward in address order. The byte at address a is taken from bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word read at a with its two low bits cleared. A memory request and a valid output byte never occur in the same cycle.
- R3: In gather mode descriptor i is read from base + 8*i, with the count word at that address and the buffer address word at the next word. Bits 30:0 of the count word give the segment byte count and bit 31 set marks the final descriptor.
- R4: The segments are streamed back to back with no gap bytes. Segments of 6, 3 and 3 bytes give the same stream as one 12-byte direct buffer with the same contents.
- R5: A descriptor with a zero count that is not final adds no bytes, and the walk continues with the next descriptor.
- R6: A final descriptor with a zero count ends the message at once. No byte of that message carries the last marker, and done still pulses once. A direct job with a zero count likewise gives no bytes and a single done pulse.
- R7: While out_valid_o is high and out_ready_i is low, the valid, data and last outputs hold their values into the next cycle.
- R8: Exactly one byte per message carries out_last_o: the final byte of a non-empty final segment.
- R9: done_o is high for exactly one cycle. When the message has a last-marked byte, done_o is high in the cycle right after that byte is accepted.
- R10: no_pad_o is high only together with done_o, and it is high exactly when accum_i was high at the accepted start.
- R11: A start pulse while a job is in progress, including its done cycle, is ignored. The running message is unchanged and no new job follows it.
- R12: mem_req_o stays high with a stable word-aligned address until mem_rvalid_i returns, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Job start pulse, taken only when idle |
| sg_en_i | input | 1 | 1: base is a descriptor list; 0: base is the data |
| accum_i | input | 1 | Data already padded; sets no_pad_o at done |
| src_addr_i | input | AW | List base or data base address |
| byte_cnt_i | input | LEN_W | Message byte count for direct mode |
| mem_req_o | output | 1 | Word read request, held until response |
| mem_addr_o | output | AW | Word-aligned read address |
| mem_rvalid_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | 32 | Read data, little-endian byte lanes |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of the message |
| out_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle end-of-job pulse |
| no_pad_o | output | 1 | Padding must be skipped; valid with done_o |

## Verification
Two events can fall in the same cycle: a new start request, and the job's own done cycle or final byte hand-off. The bench provokes this by holding start_i high, with different mode and address values, from the cycle after the real start until it sees done_o. This covers every busy cycle, the done cycle included. The result passes only if the original message comes out unchanged with a single done pulse, and no memory request follows in the idle cycles after it. Random backpressure and random memory latency also make the final-byte hand-off land in many different cycles relative to the word fetches.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned WORD_W     = 8 * WORD_BYTES;
   localparam int unsigned FINAL_BIT  = 31;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CNT,
      ST_PTR,
      ST_CHK,
      ST_FETCH,
      ST_EMIT,
      ST_DONE
   } sgs_state_e;
endpackage

// File: rtl/sgs_byte_lane.sv
module sgs_byte_lane #(
   parameter int unsigned NBYTES = 4,
   localparam int unsigned SEL_W = $clog2(NBYTES)
) (
   input  logic [8*NBYTES-1:0] word_i,
   input  logic [SEL_W-1:0]    sel_i,
   output logic [7:0]          byte_o
);
   logic [7:0] lanes [NBYTES];

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      assign lanes[g] = word_i[8*g +: 8];
   end

   assign byte_o = lanes[sel_i];
endmodule

// File: rtl/sgs_ctrl.sv
module sgs_ctrl
   import sgs_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned LEN_W = 31,
   localparam int unsigned SEL_W = $clog2(WORD_BYTES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              sg_en_i,
   input  logic              accum_i,
   input  logic [AW-1:0]     src_addr_i,
   input  logic [LEN_W-1:0]  byte_cnt_i,
   output logic              mem_req_o,
   output logic [AW-1:0]     mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic [WORD_W-1:0] word_o,
   output logic [SEL_W-1:0]  lane_o,
   output logic              emit_o,
   output logic              final_o,
   input  logic              ready_i,
   output logic              done_o,
   output logic              no_pad_o
);
   sgs_state_e        state_q;
   logic [AW-1:0]     list_q;
   logic [AW-1:0]     seg_addr_q;
   logic [LEN_W-1:0]  seg_left_q;
   logic              final_seg_q;
   logic              accum_q;
   logic [WORD_W-1:0] word_q;
   logic              one_left;
   logic              lane_end;

   assign one_left = (seg_left_q == LEN_W'(1));
   assign lane_end = (seg_addr_q[SEL_W-1:0] == {SEL_W{1'b1}});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         list_q      <= '0;
         seg_addr_q  <= '0;
         seg_left_q  <= '0;
         final_seg_q <= 1'b0;
         accum_q     <= 1'b0;
         word_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               accum_q <= accum_i;
               if (sg_en_i) begin
                  list_q  <= src_addr_i;
                  state_q <= ST_CNT;
               end else begin
                  seg_addr_q  <= src_addr_i;
                  seg_left_q  <= byte_cnt_i;
                  final_seg_q <= 1'b1;
                  state_q     <= ST_CHK;
               end
            end
            ST_CNT: if (mem_rvalid_i) begin
               seg_left_q  <= mem_rdata_i[LEN_W-1:0];
               final_seg_q <= mem_rdata_i[FINAL_BIT];
               list_q      <= list_q + AW'(WORD_BYTES);
               state_q     <= ST_PTR;
            end
            ST_PTR: if (mem_rvalid_i) begin
               seg_addr_q <= mem_rdata_i[AW-1:0];
               list_q     <= list_q + AW'(WORD_BYTES);
               state_q    <= ST_CHK;
            end
            ST_CHK: begin
               if (seg_left_q != '0) state_q <= ST_FETCH;
               else if (final_seg_q) state_q <= ST_DONE;
               else                  state_q <= ST_CNT;
            end
            ST_FETCH: if (mem_rvalid_i) begin
               word_q  <= mem_rdata_i;
               state_q <= ST_EMIT;
            end
            ST_EMIT: if (ready_i) begin
               seg_addr_q <= seg_addr_q + AW'(1);
               seg_left_q <= seg_left_q - LEN_W'(1);
               if (one_left)      state_q <= final_seg_q ? ST_DONE : ST_CNT;
               else if (lane_end) state_q <= ST_FETCH;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o  = (state_q == ST_CNT) || (state_q == ST_PTR) || (state_q == ST_FETCH);
      mem_addr_o = (state_q == ST_FETCH) ? seg_addr_q : list_q;
      mem_addr_o[SEL_W-1:0] = '0;
   end

   assign word_o   = word_q;
   assign lane_o   = seg_addr_q[SEL_W-1:0];
   assign emit_o   = (state_q == ST_EMIT);
   assign final_o  = emit_o && final_seg_q && one_left;
   assign done_o   = (state_q == ST_DONE);
   assign no_pad_o = done_o && accum_q;
endmodule

// File: rtl/sg_gather_seq.sv
module sg_gather_seq
   import sgs_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned LEN_W = 31
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              sg_en_i,
   input  logic              accum_i,
   input  logic [AW-1:0]     src_addr_i,
   input  logic [LEN_W-1:0]  byte_cnt_i,
   output logic              mem_req_o,
   output logic [AW-1:0]     mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic              out_valid_o,
   output logic [7:0]        out_data_o,
   output logic              out_last_o,
   input  logic              out_ready_i,
   output logic              done_o,
   output logic              no_pad_o
);
   localparam int unsigned SEL_W = $clog2(WORD_BYTES);

   if (AW > WORD_W || AW <= SEL_W) begin : g_bad_aw
      $error("sg_gather_seq: AW must lie in (%0d, %0d]", SEL_W, WORD_W);
   end
   if (LEN_W > FINAL_BIT || LEN_W < 1) begin : g_bad_len
      $error("sg_gather_seq: LEN_W must lie in [1, %0d]", FINAL_BIT);
   end

   logic [WORD_W-1:0] word;
   logic [SEL_W-1:0]  lane;

   sgs_ctrl #(.AW(AW), .LEN_W(LEN_W)) ctrl_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .sg_en_i     (sg_en_i),
      .accum_i     (accum_i),
      .src_addr_i  (src_addr_i),
      .byte_cnt_i  (byte_cnt_i),
      .mem_req_o   (mem_req_o),
      .mem_addr_o  (mem_addr_o),
      .mem_rvalid_i(mem_rvalid_i),
      .mem_rdata_i (mem_rdata_i),
      .word_o      (word),
      .lane_o      (lane),
      .emit_o      (out_valid_o),
      .final_o     (out_last_o),
      .ready_i     (out_ready_i),
      .done_o      (done_o),
      .no_pad_o    (no_pad_o)
   );

   sgs_byte_lane #(.NBYTES(WORD_BYTES)) lane_i (
      .word_i(word),
      .sel_i (lane),
      .byte_o(out_data_o)
   );
endmodule

// File: rtl/sgs_checker.sv
module sgs_checker #(
   parameter int unsigned AW = 32
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          mem_req_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          mem_rvalid_i,
   input logic          out_valid_o,
   input logic [7:0]    out_data_o,
   input logic          out_last_o,
   input logic          out_ready_i,
   input logic          done_o,
   input logic          no_pad_o
);
   assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> !mem_req_o);

   assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

   assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_last_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && out_ready_i && out_last_o |=> done_o);

   assert_nopad_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      no_pad_o |-> done_o);

   assert_align_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> mem_addr_o[1:0] == 2'b00);

   assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
endmodule

bind sg_gather_seq sgs_checker #(.AW(AW)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .mem_req_o   (mem_req_o),
   .mem_addr_o  (mem_addr_o),
   .mem_rvalid_i(mem_rvalid_i),
   .out_valid_o (out_valid_o),
   .out_data_o  (out_data_o),
   .out_last_o  (out_last_o),
   .out_ready_i (out_ready_i),
   .done_o      (done_o),
   .no_pad_o    (no_pad_o)
);

// File: tb/sg_gather_seq_tb.sv
module sg_gather_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int LEN_W = 31;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic             start_i = 1'b0;
   logic             sg_en_i = 1'b0;
   logic             accum_i = 1'b0;
   logic [AW-1:0]    src_addr_i = '0;
   logic [LEN_W-1:0] byte_cnt_i = '0;
   logic             mem_req_o;
   logic [AW-1:0]    mem_addr_o;
   logic             mem_rvalid_i = 1'b0;
   logic [31:0]      mem_rdata_i = '0;
   logic             out_valid_o;
   logic [7:0]       out_data_o;
   logic             out_last_o;
   logic             out_ready_i = 1'b0;
   logic             done_o;
   logic             no_pad_o;

   sg_gather_seq #(.AW(AW), .LEN_W(LEN_W)) dut_i (.*);

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0] mb [4096];
   logic [7:0] got_q [$];
   logic [7:0] exp_q [$];
   logic [7:0] ref_q [$];
   int  exp_last;
   int  last_cnt, last_at, done_cnt, done_cyc, accept_cyc, cyc;
   bit  nopad_seen, prev_stall, prev_last;
   logic [7:0] prev_data;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_word(input logic [31:0] a);
      logic [11:0] b;
      b = {a[11:2], 2'b00};
      return {mb[b + 12'd3], mb[b + 12'd2], mb[b + 12'd1], mb[b]};
   endfunction

   task automatic wr_word(input logic [31:0] a, input logic [31:0] v);
      for (int k = 0; k < 4; k++) mb[12'(a + k)] = v[8*k +: 8];
   endtask

   // reference walk of the message, built from the requirement text
   task automatic build_exp(input bit sg, input logic [31:0] base, input int len);
      exp_q.delete();
      exp_last = -1;
      if (!sg) begin
         for (int k = 0; k < len; k++) exp_q.push_back(mb[12'(base + k)]);
         if (len > 0) exp_last = len - 1;
      end else begin
         logic [31:0] p, cw, aw;
         p = {base[31:2], 2'b00};
         for (int d = 0; d < 64; d++) begin
            cw = rd_word(p);
            aw = rd_word(p + 4);
            for (int k = 0; k < int'(cw[30:0]); k++) exp_q.push_back(mb[12'(aw + k)]);
            p = p + 8;
            if (cw[31]) begin
               if (cw[30:0] != 0) exp_last = exp_q.size() - 1;
               break;
            end
         end
      end
   endtask

   // memory responder with random latency
   initial begin
      int dly = 0;
      forever begin
         @(posedge clk_i);
         if (mem_rvalid_i) mem_rvalid_i <= 1'b0;
         else if (mem_req_o) begin
            if (dly == 0) begin
               mem_rvalid_i <= 1'b1;
               mem_rdata_i  <= rd_word(mem_addr_o);
               dly = $urandom % 3;
            end else dly--;
         end
      end
   end

   // output collector and random backpressure
   initial begin
      forever begin
         @(negedge clk_i);
         if (prev_stall)
            chk(out_valid_o && out_data_o == prev_data && out_last_o == prev_last,
                "R7 stalled byte held", {out_valid_o, out_data_o}, {1'b1, prev_data});
         if (mem_req_o && mem_addr_o[1:0] != 2'b00)
            chk(1'b0, "R12 aligned address", mem_addr_o, {mem_addr_o[31:2], 2'b00});
         if (mem_req_o && out_valid_o)
            chk(1'b0, "R2 request with valid byte", 1, 0);
         out_ready_i = ($urandom % 4) != 0;
         if (out_valid_o && out_ready_i) begin
            got_q.push_back(out_data_o);
            accept_cyc = cyc;
            if (out_last_o) begin
               last_cnt++;
               last_at = got_q.size() - 1;
            end
         end
         prev_stall = out_valid_o && !out_ready_i;
         prev_data  = out_data_o;
         prev_last  = out_last_o;
         if (done_o) begin
            done_cnt++;
            done_cyc   = cyc;
            nopad_seen = no_pad_o;
         end
         cyc++;
      end
   end

   task automatic run(input bit sg, input bit acc, input logic [31:0] base, input int len,
                      input bit hold, input string tag);
      bit seen;
      build_exp(sg, base, len);
      @(negedge clk_i);
      got_q.delete();
      last_cnt = 0; last_at = -1; done_cnt = 0; done_cyc = -1; accept_cyc = -100;
      start_i = 1'b1; sg_en_i = sg; accum_i = acc;
      src_addr_i = base; byte_cnt_i = LEN_W'(len);
      @(negedge clk_i);
      if (hold) begin
         sg_en_i = !sg; accum_i = !acc; src_addr_i = 32'h7F8; byte_cnt_i = 7;
      end else start_i = 1'b0;
      seen = 1'b0;
      for (int w = 0; w < 4000 && !seen; w++) begin
         if (done_o) seen = 1'b1;
         else @(negedge clk_i);
      end
      start_i = 1'b0;
      @(negedge clk_i);
      chk(seen && done_cnt == 1, {tag, " R9 one done pulse"}, done_cnt, 1);
      chk(got_q.size() == exp_q.size(), {tag, " byte count"}, got_q.size(), exp_q.size());
      for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
         if (got_q[k] != exp_q[k]) begin
            chk(1'b0, $sformatf("%s byte %0d", tag, k), got_q[k], exp_q[k]);
            break;
         end
      if (exp_last >= 0) begin
         chk(last_cnt == 1 && last_at == exp_last, {tag, " R8 last marker index"}, last_at, exp_last);
         chk(done_cyc == accept_cyc + 1, {tag, " R9 done after final byte"}, done_cyc, accept_cyc + 1);
      end else
         chk(last_cnt == 0, {tag, " R6 no last marker"}, last_cnt, 0);
      chk(nopad_seen == acc, {tag, " R10 no_pad"}, nopad_seen, acc);
      if (hold) begin
         bit idle = 1'b1;
         for (int w = 0; w < 5; w++) begin
            if (mem_req_o || out_valid_o || done_o) idle = 1'b0;
            @(negedge clk_i);
         end
         chk(idle, {tag, " R11 stays idle after held start"}, !idle, 0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1207));
      for (int k = 0; k < 4096; k++) mb[k] = 8'($urandom);
      repeat (3) @(negedge clk_i);
      chk(!out_valid_o && !mem_req_o && !done_o, "R1 reset idle",
          {out_valid_o, mem_req_o, done_o}, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk(!out_valid_o && !mem_req_o && !done_o, "R1 idle after release",
          {out_valid_o, mem_req_o, done_o}, 0);

      // R2: direct, unaligned "abc"
      mb[12'h101] = 8'h61; mb[12'h102] = 8'h62; mb[12'h103] = 8'h63;
      run(1'b0, 1'b0, 32'h101, 3, 1'b0, "R2 direct abc");

      // R4: 12 contiguous bytes vs. 6+3+3 gather
      for (int k = 0; k < 12; k++) mb[12'h200 + k] = 8'h61 + 8'(k);
      run(1'b0, 1'b0, 32'h200, 12, 1'b0, "R4 direct 12");
      ref_q = got_q;
      for (int k = 0; k < 6; k++) mb[12'h301 + k] = 8'h61 + 8'(k);
      for (int k = 0; k < 3; k++) mb[12'h40e + k] = 8'h67 + 8'(k);
      for (int k = 0; k < 3; k++) mb[12'h523 + k] = 8'h6a + 8'(k);
      wr_word(32'h040, 32'd6);  wr_word(32'h044, 32'h301);
      wr_word(32'h048, 32'd3);  wr_word(32'h04c, 32'h40e);
      wr_word(32'h050, 32'h8000_0003); wr_word(32'h054, 32'h523);
      run(1'b1, 1'b0, 32'h040, 0, 1'b0, "R3 gather 6/3/3");
      chk(got_q == ref_q, "R4 gather equals contiguous", got_q.size(), ref_q.size());

      // R5: zero-count middle descriptor
      wr_word(32'h080, 32'd2);  wr_word(32'h084, 32'h600);
      wr_word(32'h088, 32'd0);  wr_word(32'h08c, 32'h700);
      wr_word(32'h090, 32'h8000_0005); wr_word(32'h094, 32'h803);
      run(1'b1, 1'b0, 32'h080, 0, 1'b0, "R5 skip empty");

      // R6: zero-count final descriptor, then zero-length direct
      wr_word(32'h0c0, 32'd4);  wr_word(32'h0c4, 32'h902);
      wr_word(32'h0c8, 32'h8000_0000); wr_word(32'h0cc, 32'h900);
      run(1'b1, 1'b0, 32'h0c0, 0, 1'b0, "R6 empty final");
      run(1'b0, 1'b0, 32'h300, 0, 1'b0, "R6 direct empty");

      // R10: accumulate flag, R11: start held through the job
      run(1'b1, 1'b1, 32'h040, 0, 1'b0, "R10 accum gather");
      run(1'b1, 1'b0, 32'h080, 0, 1'b1, "R11 held start gather");
      run(1'b0, 1'b1, 32'h205, 9, 1'b1, "R11 held start direct");

      // random mix
      for (int r = 0; r < 24; r++) begin
         bit acc = 1'($urandom);
         bit hold = (r % 5) == 0;
         if (r % 4 == 3) begin
            run(1'b0, acc, 32'h400 + ($urandom % 12'hA00), $urandom % 21, hold, "R2 random direct");
         end else begin
            int nseg = 1 + $urandom % 4;
            for (int s = 0; s < nseg; s++) begin
               logic [31:0] cw;
               cw = $urandom % 10;
               if (s == nseg - 1) cw[31] = 1'b1;
               wr_word(32'h100 + 8*s, cw);
               wr_word(32'h104 + 8*s, 32'h400 + ($urandom % 12'hA00));
            end
            run(1'b1, acc, 32'h100, 0, hold, "R3 random gather");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule